// File: doc/BRIEF.md
# Exception Entry Controller for Shadow Register Sets

This block sits beside the control-register file of a processor core that has several shadow register sets. When the core takes a synchronous exception, or an interrupt from the internal controller is accepted, the block works out the status word the handler runs under. It also produces the context-save writes (saved status and return address), the register set to switch to and the handler's start address. The register file and the status register stay outside and only consume these results.

An entry is requested either by the exception strobe or by the interrupt gate. The gate accepts an interrupt when the global interrupt enable bit of the current status is set and at least one pending line is also enabled. All results are registered and appear one cycle after the request, together with a one-cycle `entry_fire` pulse. The handler always runs in register set 0. The previous set number is remembered in the status word so that the return path can restore it. A nested entry, taken while the exception bit is already set, leaves the earlier saved context alone.

Status bit layout used throughout: bit 0 is the global interrupt enable (PIE), bit 1 is user mode (U), bit 2 is the exception flag (EH), bits 15:10 hold the current register set (CRS) and bits 21:16 hold the previous register set (PRS).

Top module: `exc_entry_unit`

## Requirements
- R1: An entry is started when `exc_req` is 1 or the interrupt gate accepts. `entry_fire` is 1 in the cycle after the request edge and 0 in any cycle after an edge with no request.
- R2: The interrupt gate accepts only when status bit 0 (PIE) is 1 and `irq_pend & irq_en` has at least one bit set. Otherwise, with `exc_req` low, no entry is started.
- R3: On entry, the new status has bits 15:10 (CRS) equal to 0.
- R4: On entry with old bit 2 (EH) equal to 0, new bits 21:16 (PRS) equal the old bits 15:10. With old EH equal to 1, PRS keeps its old value.
- R5: On entry, new bit 0 (PIE) and bit 1 (U) are 0 and bit 2 (EH) is 1. All bits other than 0, 1, 2, 15:10 and 21:16 are copied from the old status.
- R6: `estatus_we` and `ea_we` are 1 on an entry whose old EH was 0, and 0 on an entry whose old EH was 1. `estatus_data` is the old status and `ea_data` is the old PC plus 4.
- R7: `rs_sel`, the register set to activate and the one whose return-address register is written, is 0 after every entry.
- R8: `next_pc` equals the vector address presented with the request.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request |
| irq_pend | input | NIRQ | Pending interrupt lines |
| irq_en | input | NIRQ | Interrupt enable mask |
| cur_status | input | 32 | Status word before entry |
| vec_addr | input | AW | Exception vector address |
| cur_pc | input | AW | PC of the excepting instruction |
| entry_fire | output | 1 | One-cycle pulse, entry results valid |
| new_status | output | 32 | Status word for the handler |
| estatus_we | output | 1 | Write enable for the saved-status register |
| estatus_data | output | 32 | Value for the saved-status register |
| ea_we | output | 1 | Write enable for the return-address register |
| ea_data | output | AW | Return address |
| rs_sel | output | 6 | Register set to activate |
| next_pc | output | AW | Handler start address |

## Verification
The properties assume that every input is stable and known at the clock edge, and that the status word presented with a request is the live one, meaning the previous entry has already been written back. They make no assumption on PRS or the upper status bits. The bench drives each request on the falling edge, holds it across exactly one rising edge and then drops it. Its status words are built from explicit CRS, EH, PIE and U values plus a fixed filler pattern, so each assumed field is set on purpose.

// File: rtl/eei_pkg.sv
package eei_pkg;
  localparam int SW       = 32;
  localparam int RSW      = 6;
  localparam int PIE_B    = 0;
  localparam int U_B      = 1;
  localparam int EH_B     = 2;
  localparam int CRS_LO   = 10;
  localparam int PRS_LO   = 16;

  function automatic logic [RSW-1:0] get_crs(input logic [SW-1:0] s);
    return s[CRS_LO +: RSW];
  endfunction

  function automatic logic [RSW-1:0] get_prs(input logic [SW-1:0] s);
    return s[PRS_LO +: RSW];
  endfunction

  // Status word the handler runs under.
  function automatic logic [SW-1:0] entry_status(input logic [SW-1:0] s);
    logic [SW-1:0] r;
    r = s;
    r[CRS_LO +: RSW] = '0;
    if (!s[EH_B]) r[PRS_LO +: RSW] = s[CRS_LO +: RSW];
    r[PIE_B] = 1'b0;
    r[U_B]   = 1'b0;
    r[EH_B]  = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/eei_irq_gate.sv
module eei_irq_gate #(
  parameter int NIRQ = 32
) (
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] en,
  input  logic            pie,
  output logic            accept
);
  logic [NIRQ-1:0] live;
  for (genvar i = 0; i < NIRQ; i++) begin : g_line
    assign live[i] = pend[i] & en[i];
  end
  assign accept = pie & (|live);
endmodule

// File: rtl/eei_status_xform.sv
module eei_status_xform
  import eei_pkg::*;
(
  input  logic [SW-1:0]  old_status,
  output logic [SW-1:0]  nxt_status,
  output logic           save_ctx,
  output logic [RSW-1:0] nxt_rs
);
  assign nxt_status = entry_status(old_status);
  assign save_ctx   = ~old_status[EH_B];
  assign nxt_rs     = get_crs(nxt_status);
endmodule

// File: rtl/eei_out_stage.sv
module eei_out_stage
  import eei_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           save_ctx,
  input  logic [SW-1:0]  nxt_status,
  input  logic [SW-1:0]  old_status,
  input  logic [RSW-1:0] nxt_rs,
  input  logic [AW-1:0]  vec_addr,
  input  logic [AW-1:0]  cur_pc,
  output logic           fire,
  output logic [SW-1:0]  status_q,
  output logic           es_we,
  output logic [SW-1:0]  es_data,
  output logic           ra_we,
  output logic [AW-1:0]  ra_data,
  output logic [RSW-1:0] rs_q,
  output logic [AW-1:0]  pc_q
);
  localparam logic [AW-1:0] INSN_BYTES = AW'(4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fire     <= 1'b0;
      status_q <= '0;
      es_we    <= 1'b0;
      es_data  <= '0;
      ra_we    <= 1'b0;
      ra_data  <= '0;
      rs_q     <= '0;
      pc_q     <= '0;
    end else begin
      fire  <= take;
      es_we <= take & save_ctx;
      ra_we <= take & save_ctx;
      if (take) begin
        status_q <= nxt_status;
        es_data  <= old_status;
        ra_data  <= cur_pc + INSN_BYTES;
        rs_q     <= nxt_rs;
        pc_q     <= vec_addr;
      end
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import eei_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NIRQ = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_req,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_en,
  input  logic [31:0]     cur_status,
  input  logic [AW-1:0]   vec_addr,
  input  logic [AW-1:0]   cur_pc,
  output logic            entry_fire,
  output logic [31:0]     new_status,
  output logic            estatus_we,
  output logic [31:0]     estatus_data,
  output logic            ea_we,
  output logic [AW-1:0]   ea_data,
  output logic [5:0]      rs_sel,
  output logic [AW-1:0]   next_pc
);
  logic           irq_accept;
  logic           entry_take;
  logic [SW-1:0]  nxt_status;
  logic           save_ctx;
  logic [RSW-1:0] nxt_rs;

  eei_irq_gate #(.NIRQ(NIRQ)) u_gate (
    .pend   (irq_pend),
    .en     (irq_en),
    .pie    (cur_status[PIE_B]),
    .accept (irq_accept)
  );

  assign entry_take = exc_req | irq_accept;

  eei_status_xform u_xform (
    .old_status (cur_status),
    .nxt_status (nxt_status),
    .save_ctx   (save_ctx),
    .nxt_rs     (nxt_rs)
  );

  eei_out_stage #(.AW(AW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (entry_take),
    .save_ctx   (save_ctx),
    .nxt_status (nxt_status),
    .old_status (cur_status),
    .nxt_rs     (nxt_rs),
    .vec_addr   (vec_addr),
    .cur_pc     (cur_pc),
    .fire       (entry_fire),
    .status_q   (new_status),
    .es_we      (estatus_we),
    .es_data    (estatus_data),
    .ra_we      (ea_we),
    .ra_data    (ea_data),
    .rs_q       (rs_sel),
    .pc_q       (next_pc)
  );
endmodule

// File: rtl/eei_chk.sv
module eei_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exc_req,
  input logic          entry_take,
  input logic [31:0]   cur_status,
  input logic [AW-1:0] vec_addr,
  input logic          entry_fire,
  input logic [31:0]   new_status,
  input logic          estatus_we,
  input logic          ea_we,
  input logic [5:0]    rs_sel,
  input logic [AW-1:0] next_pc
);
  // R1
  fire_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_take |=> entry_fire);
  // R2
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !cur_status[0]) |=> !entry_fire);
  // R3
  crs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_fire |-> new_status[15:10] == 6'd0);
  // R4
  prs_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_take && !cur_status[2]) |=> new_status[21:16] == $past(cur_status[15:10]));
  // R5
  enables_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_fire |-> (new_status[2:0] == 3'b100));
  // R6
  nested_no_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_take && cur_status[2]) |=> (!estatus_we && !ea_we));
  // R7
  set_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_fire |-> rs_sel == 6'd0);
  // R8
  vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_take |=> next_pc == $past(vec_addr));
endmodule

bind exc_entry_unit eei_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exc_req    (exc_req),
  .entry_take (entry_take),
  .cur_status (cur_status),
  .vec_addr   (vec_addr),
  .entry_fire (entry_fire),
  .new_status (new_status),
  .estatus_we (estatus_we),
  .ea_we      (ea_we),
  .rs_sel     (rs_sel),
  .next_pc    (next_pc)
);

// File: tb/sim_exc_entry_unit.sv
module sim_exc_entry_unit;
  localparam int AW = 32;
  localparam int NIRQ = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            exc_req = 1'b0;
  logic [NIRQ-1:0] irq_pend = '0;
  logic [NIRQ-1:0] irq_en = '0;
  logic [31:0]     cur_status = '0;
  logic [AW-1:0]   vec_addr = '0;
  logic [AW-1:0]   cur_pc = '0;
  logic            entry_fire;
  logic [31:0]     new_status;
  logic            estatus_we;
  logic [31:0]     estatus_data;
  logic            ea_we;
  logic [AW-1:0]   ea_data;
  logic [5:0]      rs_sel;
  logic [AW-1:0]   next_pc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_entry_unit #(.AW(AW), .NIRQ(NIRQ)) u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected handler status built field by field.
  function automatic logic [31:0] model_status(input logic [31:0] s);
    logic [31:0] keep;
    logic [5:0]  prs;
    keep = s & ~(32'h003F_FC00 | 32'h7);
    prs  = s[2] ? s[21:16] : s[15:10];
    return keep | ({26'd0, prs} << 16) | 32'h4;
  endfunction

  // Present one request across a single rising edge, then sample.
  task automatic one_entry(input bit exc, input logic [31:0] pend,
                           input logic [31:0] en, input logic [31:0] st,
                           input logic [31:0] vec, input logic [31:0] pc);
    @(negedge clk);
    exc_req = exc; irq_pend = pend; irq_en = en;
    cur_status = st; vec_addr = vec; cur_pc = pc;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    exc_req = 1'b0; irq_pend = '0; irq_en = '0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] st, vec, pc;
    logic        want;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check(entry_fire == 0 && estatus_we == 0 && ea_we == 0, "R9 flags",
          {29'd0, entry_fire, estatus_we, ea_we}, 32'd0);
    check(new_status == 0 && estatus_data == 0, "R9 status", new_status, 32'd0);
    check(ea_data == 0 && next_pc == 0 && rs_sel == 0, "R9 addr", next_pc, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Exception sweep over every CRS, both EH values, PIE/U combos.
    for (int crs = 0; crs < 64; crs++) begin
      for (int eh = 0; eh < 2; eh++) begin
        for (int pu = 0; pu < 4; pu++) begin
          st = 32'hA580_0000 ^ (32'(crs) * 32'h0100_0000);
          st[21:16] = 6'(63 - crs);
          st[15:10] = 6'(crs);
          st[9:3]   = 7'(crs * 3 + pu);
          st[2]     = 1'(eh);
          st[1:0]   = 2'(pu);
          vec = 32'h0000_1000 + 32'(crs * 32 + pu * 4);
          pc  = 32'h0040_0000 + 32'(crs * 256 + eh * 16 + pu * 4);
          one_entry(1'b1, 32'd0, 32'd0, st, vec, pc);
          check(entry_fire == 1'b1, "R1 fire", {31'd0, entry_fire}, 32'd1);
          check(new_status[15:10] == 6'd0, "R3 crs", new_status, model_status(st));
          check(new_status[21:16] == (eh != 0 ? st[21:16] : st[15:10]), "R4 prs",
                new_status, model_status(st));
          check(new_status == model_status(st), "R5 status", new_status,
                model_status(st));
          check(estatus_we == (eh == 0) && ea_we == (eh == 0), "R6 we",
                {30'd0, estatus_we, ea_we}, (eh == 0) ? 32'd3 : 32'd0);
          if (eh == 0) begin
            check(estatus_data == st, "R6 estatus", estatus_data, st);
            check(ea_data == pc + 32'd4, "R6 ea", ea_data, pc + 32'd4);
          end
          check(rs_sel == 6'd0, "R7 set", {26'd0, rs_sel}, 32'd0);
          check(next_pc == vec, "R8 vector", next_pc, vec);
        end
      end
      if (crs % 8 == 0) begin
        idle_cycle();
        check(entry_fire == 0 && estatus_we == 0 && ea_we == 0, "R1 idle",
              {29'd0, entry_fire, estatus_we, ea_we}, 32'd0);
      end
    end

    // Interrupt gate sweep: every line, overlapping or not, PIE on/off.
    for (int pie = 0; pie < 2; pie++) begin
      for (int i = 0; i < NIRQ; i++) begin
        for (int ov = 0; ov < 2; ov++) begin
          logic [31:0] p, e;
          p = 32'd1 << i;
          e = ov != 0 ? p : (32'd1 << ((i + 1) % NIRQ));
          st = 32'h0000_0000 | (32'(i % 64) << 10) | 32'(pie);
          want = (pie != 0) && (ov != 0);
          one_entry(1'b0, p, e, st, 32'h0000_2000 + 32'(i), 32'h100 + 32'(i * 4));
          check(entry_fire == want, "R2 gate", {31'd0, entry_fire}, {31'd0, want});
          if (want) begin
            check(new_status == model_status(st), "R2 irq status", new_status,
                  model_status(st));
            check(next_pc == 32'h0000_2000 + 32'(i), "R8 irq vector", next_pc,
                  32'h0000_2000 + 32'(i));
          end
          idle_cycle();
          check(entry_fire == 1'b0, "R1 drop", {31'd0, entry_fire}, 32'd0);
        end
      end
    end

    // Nested entry back to back: saved context left untouched.
    st = 32'h0000_2C01;
    one_entry(1'b1, 32'd0, 32'd0, st, 32'h80, 32'h500);
    check(estatus_we == 1'b1 && ea_data == 32'h504, "R6 outer", ea_data, 32'h504);
    st = model_status(st);
    one_entry(1'b1, 32'd0, 32'd0, st, 32'h80, 32'h900);
    check(estatus_we == 1'b0 && ea_we == 1'b0, "R6 nested",
          {30'd0, estatus_we, ea_we}, 32'd0);
    check(new_status[21:16] == 6'd11, "R4 nested prs", {26'd0, new_status[21:16]},
          32'd11);
    idle_cycle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule